// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block is the digital controller that sits beside a successive-approximation converter. Software talks to it through a small word-addressed register port. Writing a channel number to the channel register starts one conversion. A separate control bit starts a calibration run. The block divides the system clock down to a converter tick and walks through three phases, all counted in ticks. A fixed start overhead comes first. Then comes a programmable sample window, then a base conversion window of 25 ticks. The sample and conversion windows repeat once for each averaged sample.

At the end of each base conversion window the block pulses `smp_strobe`. The raw 12-bit sample on `smp_data` is captured on that same clock edge. This port has no back-pressure: `smp_data` must be valid in every cycle where `smp_strobe` is high, and the block never waits for it. The samples are summed, the sum is divided by the sample count and the quotient is masked to the chosen resolution. The result is then stored, a completion flag is set, and an interrupt is raised if it is enabled. All register-port signals are plain control pins. `rdata` is combinational from `addr`.

Register words (`addr`): 0 channel control, 1 status, 2 result, 3 configuration, 4 general control, 5 general status.

Top module: `adc_seq`

## Requirements
- R1: A conversion takes 6 + N×(25 + L) converter ticks. The completion flag (status word bit 0) reads 1 from exactly P×(6 + N×(25 + L)) clock edges after the edge that accepted the start write, and reads 0 one edge earlier.
- R2: The sample window L comes from configuration bit 4 (long) and bits [6:5] (sel). With long=0, L is 3 + 2×sel (3, 5, 7, 9). With long=1, L is 13 + 4×sel (13, 17, 21, 25).
- R3: The sample count N is 1 when configuration bit 7 (average enable) is 0. Otherwise N is 4, 8, 16 or 32 for configuration bits [9:8] equal to 0, 1, 2 or 3.
- R4: The converter tick runs at the clock rate divided by P = 1, 2, 4 or 8, selected by configuration bits [3:2] equal to 0 to 3.
- R5: The stored result (result word bits [11:0]) is the sum of the N samples shifted right by log2(N), masked to the resolution in configuration bits [1:0]: 0 keeps 8 bits, 1 keeps 10 bits, 2 or 3 keeps 12 bits.
- R6: Writing channel code 0x1F to channel-control bits [4:0] stops any conversion in progress. No further strobe follows, and no result or flag is produced.
- R7: Reading the result word with `rd_en` high clears the completion flag on that edge. `irq` equals the flag ANDed with channel-control bit 7.
- R8: When a conversion ends while the flag is still set, its result replaces the stored one only if configuration bit 10 (overwrite) is 1. Otherwise the new result is dropped.
- R9: Writing general-control bit 7 starts a calibration of 32 samples, using the configured sample window. General-status bit 0 reads 1 while it runs. At the end it sets the completion flag and leaves the stored result unchanged.
- R10: Writing a channel other than 0x1F while calibration runs aborts the calibration, sets general-status bit 1 (failure) and starts no conversion. A new calibration start clears the failure bit.
- R11: `smp_strobe` is a single-cycle pulse. It goes high exactly N times per conversion and is never high on two consecutive cycles.
- R12: After reset, every register word reads 0, and `irq` and `smp_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on the result word only) |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| smp_strobe | output | 1 | Pulse: capture smp_data on this edge |
| smp_data | input | 12 | Raw sample from the converter |
| chan_sel | output | 5 | Selected analog channel |
| irq | output | 1 | Completion interrupt |

## Verification
Each result is due exactly P×(6 + N×(25 + L)) edges after the edge that accepts the start write. The bench derives that count from the vector fields. It reads the flag one edge before the due edge, expecting 0, and again on the due edge, expecting 1. Strobe count, interrupt and result value are all checked at that same instant. The calibration busy bit and the abort failure bit are due on the edge that accepts the write. The stop and overwrite cases are checked after a wait longer than a full conversion. All outputs are sampled at the falling edge, half a period away from the edge that changes them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } seq_st_t;

  // configuration word, bit 0 at the bottom
  typedef struct packed {
    logic       ovw;      // [10] replace an unread result
    logic [1:0] avg_cnt;  // [9:8] 4,8,16,32 samples
    logic       avg_en;   // [7]
    logic [1:0] lsel;     // [6:5] window position in group
    logic       lng;      // [4] upper window group
    logic [1:0] div;      // [3:2] tick divider code
    logic [1:0] res;      // [1:0] result width code
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // sample window length in ticks
  function automatic logic [4:0] win_ticks(input logic lng, input logic [1:0] sel);
    return lng ? (5'd13 + {1'b0, sel, 2'b00}) : (5'd3 + {2'b00, sel, 1'b0});
  endfunction

  // log2 of averaged sample count
  function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] cnt);
    return en ? ({1'b0, cnt} + 3'd2) : 3'd0;
  endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int DIV_W = 2,
  localparam int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] lim;

  assign one_sh = (PRE_W + 1)'(1) << div;
  assign lim    = PRE_W'(one_sh - 1'b1);
  assign tick   = (pre == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (restart) pre <= '0;
    else if (tick)    pre <= '0;
    else              pre <= pre + 1'b1;
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int SMP_W     = 12,
  parameter int BASE_CYC  = 25,
  parameter int START_CYC = 6,
  parameter int MAX_LOG   = 5,
  localparam int CNT_W = $clog2(BASE_CYC),
  localparam int ACC_W = SMP_W + MAX_LOG,
  localparam int NW    = MAX_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_conv,
  input  logic             cmd_stop,
  input  logic             cmd_cal,
  input  logic [1:0]       res,
  input  logic             lng,
  input  logic [1:0]       lsel,
  input  logic             avg_en,
  input  logic [1:0]       avg_cnt,
  input  logic [SMP_W-1:0] smp_data,
  output logic             smp_strobe,
  output logic             res_vld,
  output logic [SMP_W-1:0] res_val,
  output logic             cal_end,
  output logic             cal_abort,
  output logic             busy,
  output logic             cal_busy
);
  localparam int M8  = SMP_W - 8;
  localparam int M10 = SMP_W - 10;

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [NW-1:0]    nleft;
  logic [ACC_W-1:0] acc;
  logic [2:0]       sh_q, sh_new;
  logic [4:0]       win_q;
  logic [1:0]       res_q;
  logic             cal_q;

  logic             launch, fin, last_tick;
  logic [ACC_W-1:0] sum_n, avg;
  logic [SMP_W-1:0] mask;

  assign busy      = (st != ST_IDLE);
  assign cal_busy  = busy && cal_q;
  assign cal_abort = cmd_conv && cal_busy;
  assign launch    = cmd_cal || (cmd_conv && !cal_busy);
  assign last_tick = tick && (cnt == '0);
  assign smp_strobe = (st == ST_CONV) && last_tick;
  assign fin       = smp_strobe && (nleft == '0);
  assign res_vld   = fin && !cal_q;
  assign cal_end   = fin && cal_q;

  assign sh_new = cmd_cal ? 3'(MAX_LOG) : avg_shift(avg_en, avg_cnt);
  assign sum_n  = acc + ACC_W'(smp_data);
  assign avg    = sum_n >> sh_q;
  assign mask   = (res_q == 2'd0) ? ({SMP_W{1'b1}} >> M8)
                : (res_q == 2'd1) ? ({SMP_W{1'b1}} >> M10)
                :                   {SMP_W{1'b1}};
  assign res_val = avg[SMP_W-1:0] & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      nleft <= '0;
      acc   <= '0;
      sh_q  <= '0;
      win_q <= '0;
      res_q <= '0;
      cal_q <= 1'b0;
    end else if (launch) begin
      st    <= ST_START;
      cnt   <= CNT_W'(START_CYC - 1);
      acc   <= '0;
      sh_q  <= sh_new;
      nleft <= NW'(((NW + 1)'(1) << sh_new) - (NW + 1)'(1));
      win_q <= win_ticks(lng, lsel);
      res_q <= res;
      cal_q <= cmd_cal;
    end else if (cmd_stop || cmd_conv) begin
      // stop request, or conversion request that aborts calibration
      st    <= ST_IDLE;
      cal_q <= 1'b0;
    end else if (tick) begin
      unique case (st)
        ST_START: begin
          if (cnt == '0) begin
            st  <= ST_SAMPLE;
            cnt <= CNT_W'(win_q - 5'd1);
          end else cnt <= cnt - 1'b1;
        end
        ST_SAMPLE: begin
          if (cnt == '0) begin
            st  <= ST_CONV;
            cnt <= CNT_W'(BASE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_CONV: begin
          if (cnt == '0) begin
            acc <= sum_n;
            if (nleft == '0) begin
              st    <= ST_IDLE;
              cal_q <= 1'b0;
            end else begin
              nleft <= nleft - 1'b1;
              st    <= ST_SAMPLE;
              cnt   <= CNT_W'(win_q - 5'd1);
            end
          end else cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int AW     = 3,
  parameter int DW     = 32,
  parameter int SMP_W  = 12,
  parameter int CHAN_W = 5,
  localparam logic [CHAN_W-1:0] OFF_CODE = {CHAN_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              res_vld,
  input  logic [SMP_W-1:0]  res_val,
  input  logic              cal_end,
  input  logic              cal_abort,
  input  logic              cal_busy,
  output cfg_t              cfg,
  output logic [CHAN_W-1:0] chan,
  output logic              ie,
  output logic              cmd_conv,
  output logic              cmd_stop,
  output logic              cmd_cal,
  output logic              done,
  output logic [SMP_W-1:0]  result,
  output logic              calfail
);
  localparam logic [AW-1:0] A_CH   = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_RES  = AW'(2);
  localparam logic [AW-1:0] A_CFG  = AW'(3);
  localparam logic [AW-1:0] A_GCTL = AW'(4);
  localparam logic [AW-1:0] A_GST  = AW'(5);
  localparam int IE_BIT  = 7;
  localparam int CAL_BIT = 7;

  logic ch_wr, rd_clr;
  logic unused_wbits;

  assign unused_wbits = ^wdata[DW-1:CFG_W];
  assign ch_wr    = wr_en && (addr == A_CH);
  assign cmd_conv = ch_wr && (wdata[CHAN_W-1:0] != OFF_CODE);
  assign cmd_stop = ch_wr && (wdata[CHAN_W-1:0] == OFF_CODE);
  assign cmd_cal  = wr_en && (addr == A_GCTL) && wdata[CAL_BIT];
  assign rd_clr   = rd_en && (addr == A_RES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      chan <= '0;
      ie   <= 1'b0;
    end else begin
      if (ch_wr) begin
        chan <= wdata[CHAN_W-1:0];
        ie   <= wdata[IE_BIT];
      end
      if (wr_en && (addr == A_CFG)) cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      result  <= '0;
      calfail <= 1'b0;
    end else begin
      if (res_vld && (!done || cfg.ovw)) begin
        result <= res_val;
        done   <= 1'b1;
      end else if (cal_end) begin
        done <= 1'b1;
      end else if (rd_clr) begin
        done <= 1'b0;
      end
      if (cmd_cal)        calfail <= 1'b0;
      else if (cal_abort) calfail <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CH:   rdata = DW'({ie, 2'b00, chan});
      A_STAT: rdata = DW'(done);
      A_RES:  rdata = DW'(result);
      A_CFG:  rdata = DW'(cfg);
      A_GST:  rdata = DW'({calfail, cal_busy});
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int AW        = 3,
  parameter int DW        = 32,
  parameter int SMP_W     = 12,
  parameter int CHAN_W    = 5,
  parameter int BASE_CYC  = 25,
  parameter int START_CYC = 6,
  parameter int MAX_LOG   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              smp_strobe,
  input  logic [SMP_W-1:0]  smp_data,
  output logic [CHAN_W-1:0] chan_sel,
  output logic              irq
);
  cfg_t             cfg_w;
  logic             ie, done, calfail;
  logic             cmd_conv, cmd_stop, cmd_cal;
  logic             res_vld, cal_end, cal_abort, busy, cal_busy, tick;
  logic [SMP_W-1:0] res_val, result;

  adc_seq_regs #(
    .AW(AW), .DW(DW), .SMP_W(SMP_W), .CHAN_W(CHAN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .res_vld(res_vld), .res_val(res_val),
    .cal_end(cal_end), .cal_abort(cal_abort), .cal_busy(cal_busy),
    .cfg(cfg_w), .chan(chan_sel), .ie(ie), .cmd_conv(cmd_conv),
    .cmd_stop(cmd_stop), .cmd_cal(cmd_cal), .done(done), .result(result),
    .calfail(calfail)
  );

  adc_seq_clkdiv #(.DIV_W(2)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(cmd_conv || cmd_cal),
    .div(cfg_w.div), .tick(tick)
  );

  adc_seq_core #(
    .SMP_W(SMP_W), .BASE_CYC(BASE_CYC), .START_CYC(START_CYC), .MAX_LOG(MAX_LOG)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_conv(cmd_conv),
    .cmd_stop(cmd_stop), .cmd_cal(cmd_cal), .res(cfg_w.res), .lng(cfg_w.lng),
    .lsel(cfg_w.lsel), .avg_en(cfg_w.avg_en), .avg_cnt(cfg_w.avg_cnt),
    .smp_data(smp_data), .smp_strobe(smp_strobe), .res_vld(res_vld),
    .res_val(res_val), .cal_end(cal_end), .cal_abort(cal_abort),
    .busy(busy), .cal_busy(cal_busy)
  );

  assign irq = done && ie;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int AW    = 3,
  parameter int SMP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic             res_vld,
  input logic             cal_end,
  input logic             done,
  input logic [SMP_W-1:0] result,
  input logic             ovw,
  input logic             cmd_conv,
  input logic             cmd_stop,
  input logic             cal_busy,
  input logic             calfail,
  input logic             busy,
  input logic             smp_strobe
);
  // R7
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(2) && !res_vld && !cal_end) |=> !done);

  // R8
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && done && !ovw) |=> $stable(result));

  // R10
  cal_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_conv && cal_busy) |=> (calfail && !busy));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !busy);

  // R11
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> !smp_strobe);

  // R9
  cal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_end |=> (done && !cal_busy));
endmodule

bind adc_seq adc_seq_chk #(.AW(AW), .SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .res_vld(res_vld),
  .cal_end(cal_end), .done(done), .result(result), .ovw(cfg_w.ovw),
  .cmd_conv(cmd_conv), .cmd_stop(cmd_stop), .cal_busy(cal_busy),
  .calfail(calfail), .busy(busy), .smp_strobe(smp_strobe)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        smp_strobe;
  logic [11:0] smp_data = '0;
  logic [4:0]  chan_sel;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int sidx  = 0;
  logic [11:0] g_base = '0, g_step = '0;
  bit finished = 0;

  adc_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .smp_strobe(smp_strobe),
    .smp_data(smp_data), .chan_sel(chan_sel), .irq(irq)
  );

  always #10 clk = ~clk;   // 50 MHz

  // converter model: sample k = base + k*step
  always @(negedge clk) begin
    smp_data = 12'(g_base + 12'(sidx) * g_step);
    if (smp_strobe) sidx = sidx + 1;
  end

  typedef struct packed {
    logic [1:0]  res;
    logic [1:0]  div;
    logic        lng;
    logic [1:0]  lsel;
    logic        aen;
    logic [1:0]  acnt;
    logic [11:0] base;
    logic [11:0] step;
    logic        ie;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 12'h123, 12'h000, 1'b1},
    '{2'd2, 2'd1, 1'b0, 2'd3, 1'b1, 2'd0, 12'h800, 12'h005, 1'b0},
    '{2'd1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd1, 12'hFFF, 12'h000, 1'b1},
    '{2'd0, 2'd2, 1'b1, 2'd3, 1'b1, 2'd2, 12'h100, 12'h003, 1'b1},
    '{2'd2, 2'd3, 1'b1, 2'd1, 1'b1, 2'd3, 12'h7F0, 12'h001, 1'b0},
    '{2'd3, 2'd0, 1'b0, 2'd2, 1'b0, 2'd0, 12'hABC, 12'h010, 1'b1}
  };

  localparam int WIN [8] = '{3, 5, 7, 9, 13, 17, 21, 25};

  function automatic logic [11:0] exp_avg(input logic [11:0] b, input logic [11:0] s,
                                          input int n, input int lg, input logic [1:0] res);
    int sum = 0;
    for (int k = 0; k < n; k++) sum += int'(12'(b + 12'(k) * s));
    sum = sum >> lg;
    if (res == 2'd0)      sum = sum & 'hFF;
    else if (res == 2'd1) sum = sum & 'h3FF;
    else                  sum = sum & 'hFFF;
    return 12'(sum);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b0;
    #1 v = rdata;
  endtask

  task automatic rd_clr(input logic [2:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    vec_t t;
    int p, l, n, lg, cyc;
    logic [11:0] keep;

    repeat (3) @(negedge clk);
    // R12 reset state
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), v);
      chk("R12 reg word", v, 32'h0);
    end
    chk("R12 irq", {31'h0, irq}, 32'h0);
    chk("R12 strobe", {31'h0, smp_strobe}, 32'h0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R7 R11
    for (int i = 0; i < 6; i++) begin
      t   = VEC[i];
      p   = 1 << t.div;
      l   = WIN[{t.lng, t.lsel}];
      n   = t.aen ? (4 << t.acnt) : 1;
      lg  = t.aen ? (t.acnt + 2) : 0;
      cyc = p * (6 + n * (25 + l));
      wr(3'd3, {21'h0, 1'b1, t.acnt, t.aen, t.lsel, t.lng, t.div, t.res});
      g_base = t.base; g_step = t.step; sidx = 0;
      wr(3'd0, {24'h0, t.ie, 2'b00, 5'(i + 1)});
      chk("R7 channel select", {27'h0, chan_sel}, 32'(i + 1));
      repeat (cyc - 1) @(negedge clk);
      peek(3'd1, v);
      chk("R1 R2 R3 R4 flag not early", v, 32'h0);
      @(negedge clk);
      peek(3'd1, v);
      chk("R1 R2 R3 R4 flag due", v, 32'h1);
      chk("R11 strobe count", 32'(sidx), 32'(n));
      chk("R7 irq follows enable", {31'h0, irq}, {31'h0, t.ie});
      rd_clr(3'd2, v);
      chk("R5 averaged result", v, {20'h0, exp_avg(t.base, t.step, n, lg, t.res)});
      peek(3'd1, v);
      chk("R7 read clears flag", v, 32'h0);
    end

    // R6 stop mid conversion
    wr(3'd3, 32'h0000_0402);
    g_base = 12'h055; g_step = 12'h0; sidx = 0;
    wr(3'd0, 32'h0000_0004);
    repeat (10) @(negedge clk);
    wr(3'd0, 32'h0000_001F);
    repeat (100) @(negedge clk);
    peek(3'd1, v);
    chk("R6 stop leaves flag low", v, 32'h0);
    chk("R6 stop no strobe", 32'(sidx), 32'h0);

    // R8 overwrite disabled then enabled
    wr(3'd3, 32'h0000_0002);
    g_base = 12'h111; sidx = 0;
    wr(3'd0, 32'h0000_0001);
    repeat (40) @(negedge clk);
    g_base = 12'h222; sidx = 0;
    wr(3'd0, 32'h0000_0001);
    repeat (40) @(negedge clk);
    peek(3'd2, v);
    chk("R8 unread result kept", v, 32'h111);
    wr(3'd3, 32'h0000_0402);
    g_base = 12'h333; sidx = 0;
    wr(3'd0, 32'h0000_0001);
    repeat (40) @(negedge clk);
    rd_clr(3'd2, v);
    chk("R8 overwrite replaces", v, 32'h333);
    keep = 12'h333;

    // R9 calibration: 32 samples, window 3, divide 1
    wr(3'd0, 32'h0000_009F);
    g_base = 12'h7AA; sidx = 0;
    wr(3'd4, 32'h0000_0080);
    peek(3'd5, v);
    chk("R9 calibration busy", v, 32'h1);
    repeat (6 + 32 * 28 - 1) @(negedge clk);
    peek(3'd1, v);
    chk("R9 calibration flag not early", v, 32'h0);
    @(negedge clk);
    peek(3'd1, v);
    chk("R9 calibration flag due", v, 32'h1);
    chk("R9 calibration irq", {31'h0, irq}, 32'h1);
    chk("R9 calibration sample count", 32'(sidx), 32'd32);
    peek(3'd5, v);
    chk("R9 calibration finished ok", v, 32'h0);
    rd_clr(3'd2, v);
    chk("R9 result unchanged", v, {20'h0, keep});

    // R10 abort by conversion request
    wr(3'd4, 32'h0000_0080);
    repeat (20) @(negedge clk);
    sidx = 0;
    wr(3'd0, 32'h0000_0083);
    peek(3'd5, v);
    chk("R10 abort sets failure", v, 32'h2);
    repeat (1000) @(negedge clk);
    peek(3'd1, v);
    chk("R10 no conversion after abort", v, 32'h0);
    chk("R10 no strobe after abort", 32'(sidx), 32'h0);
    wr(3'd4, 32'h0000_0080);
    peek(3'd5, v);
    chk("R10 new calibration clears failure", v, 32'h1);
    wr(3'd0, 32'h0000_001F);
    peek(3'd5, v);
    chk("R6 stop ends calibration", v, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule